// File: doc/BRIEF.md
# Critical-Conduction Boost Gate Sequencer

This block produces the switch drive for a boost stage that runs in critical conduction. Each switching period has an on phase, a blanked off phase, a wait for the inductor current to fall to zero, and a short delay before the next turn-on. The analog front end is outside the block. It supplies single-bit, already synchronised flags:
- the constant on-time ramp has met the loop control voltage;
- the inductor current has crossed the peak limit;
- the inductor current is above the minimum peak set-point;
- the zero-current comparator output.

The on phase ends on whichever termination arrives first, within minimum and maximum on-time bounds. The ramp termination is held back until the minimum peak set-point is reached, so that some input current is always drawn under deep phase dimming. If the zero-current crossing never arrives, a watchdog starts the next period anyway. A stop input kills the drive at once and parks the sequencer until it is released.

All durations are parameters in clock cycles. A period counter and a timeout-start flag make the switching history visible at the ports.

Top module: `crm_gate_seq`

## Requirements
- R1: While reset is held, `drv_o`, `cycle_cnt_o` and `timeout_o` are 0. After reset, the first clock edge that samples `stop_i` low begins an on phase.
- R2: `stop_i` high forces `drv_o` low in the same cycle, with no clock edge needed. It returns the sequencer to idle and clears both timers. The first clock edge that samples `stop_i` low again starts a fresh on phase, and that phase reports `timeout_o` = 0.
- R3: The ramp flag `ton_done_i` ends the on phase only once `drv_o` has been high for at least `TON_MIN_CYC` cycles. When honoured, the on length is max(TON_MIN_CYC, k+1), where k is the index of the first high cycle in which the flag is seen. The index counts from 0.
- R4: The peak-limit flag `ilim_i` is ignored during the first `LEB_CYC` high cycles. Held from index j, it gives an on length of max(LEB_CYC, j)+1.
- R5: The ramp flag has no effect while `imin_i` is low. The on phase continues until `imin_i` rises, `ilim_i` terminates it, or the maximum on-time is reached.
- R6: `drv_o` is never high for more than `TON_MAX_CYC` consecutive cycles. When no termination arrives, the on length is exactly `TON_MAX_CYC`.
- R7: The zero-current event is a 1-to-0 transition of `zcd_i`. It is ignored while `drv_o` is high and during the first `ZBLANK_CYC` cycles of the off phase.
- R8: A zero-current event seen at off-phase index i (counted from 0, with i >= ZBLANK_CYC) gives an off length of i+1+ZDLY_CYC cycles.
- R9: With no accepted event, `drv_o` rises again after exactly `WD_CYC` low cycles and `timeout_o` reads 1 for that period. An accepted event reads 0. An event at index WD_CYC-1 takes priority over the expiring watchdog.
- R10: `cycle_cnt_o` increments, modulo 2^CYC_W, at every rise of `drv_o`. `timeout_o` changes only at a rise of `drv_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stop_i | input | 1 | Global stop; kills the drive at once |
| ton_done_i | input | 1 | Constant on-time ramp has reached the control level |
| ilim_i | input | 1 | Inductor peak current above the limit |
| imin_i | input | 1 | Inductor current above the minimum peak set-point |
| zcd_i | input | 1 | Zero-current comparator output; a 1-to-0 transition is the event |
| drv_o | output | 1 | Switch gate drive |
| cycle_cnt_o | output | CYC_W | Count of on-phase starts, wrapping |
| timeout_o | output | 1 | Current period was started by the watchdog |

## Verification
Every input is sampled at a rising edge. An on-phase termination seen at on-index n therefore takes `drv_o` low in the following cycle, giving an on length of n+1. An accepted zero-current event at off-index i raises `drv_o` after ZDLY_CYC further cycles. The watchdog raises it after exactly WD_CYC low cycles.

The bench drives stimulus on falling edges, indexed by its own count of high or low `drv_o` samples. It measures each phase length at the falling edges and compares it with the values given by these formulas. `timeout_o` and `cycle_cnt_o` are checked at the first falling edge after each rise. The reaction to `stop_i` is checked 1 ns after it is driven, because it is combinational.

// File: rtl/crm_seq_pkg.sv
package crm_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ON    = 3'd1,
    ST_BLANK = 3'd2,
    ST_WAIT  = 3'd3,
    ST_DELAY = 3'd4
  } crm_state_e;
endpackage

// File: rtl/crm_cycle_timer.sv
module crm_cycle_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_o <= '0;
    else if (clr_i)        cnt_o <= '0;
    else if (cnt_o != '1)  cnt_o <= cnt_o + 1'b1;  // saturate
  end
endmodule

// File: rtl/crm_fall_det.sv
module crm_fall_det #(
  parameter bit INIT = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic fall_o
);
  logic d_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) d_q <= INIT;
    else         d_q <= d_i;
  end
  assign fall_o = d_q & ~d_i;
endmodule

// File: rtl/crm_gate_seq.sv
module crm_gate_seq
  import crm_seq_pkg::*;
#(
  parameter int LEB_CYC     = 13,
  parameter int TON_MIN_CYC = 30,
  parameter int TON_MAX_CYC = 900,
  parameter int ZBLANK_CYC  = 15,
  parameter int ZDLY_CYC    = 25,
  parameter int WD_CYC      = 1600,
  parameter int CYC_W       = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stop_i,
  input  logic             ton_done_i,
  input  logic             ilim_i,
  input  logic             imin_i,
  input  logic             zcd_i,
  output logic             drv_o,
  output logic [CYC_W-1:0] cycle_cnt_o,
  output logic             timeout_o
);
  localparam int PH_MAX0 = (TON_MAX_CYC > ZBLANK_CYC) ? TON_MAX_CYC : ZBLANK_CYC;
  localparam int PH_MAX  = (PH_MAX0 > ZDLY_CYC) ? PH_MAX0 : ZDLY_CYC;
  localparam int PH_W    = $clog2(PH_MAX + 1);
  localparam int WD_W    = $clog2(WD_CYC + 1);

  localparam logic [PH_W-1:0] LEB_TH  = PH_W'(LEB_CYC);
  localparam logic [PH_W-1:0] TMIN_TH = PH_W'(TON_MIN_CYC - 1);
  localparam logic [PH_W-1:0] TMAX_TH = PH_W'(TON_MAX_CYC - 1);
  localparam logic [PH_W-1:0] ZBL_TH  = PH_W'(ZBLANK_CYC - 1);
  localparam logic [PH_W-1:0] ZDLY_TH = PH_W'(ZDLY_CYC - 1);
  localparam logic [WD_W-1:0] WD_TH   = WD_W'(WD_CYC - 1);

  crm_state_e       state_q, state_d;
  logic [PH_W-1:0]  ph_cnt;
  logic [WD_W-1:0]  wd_cnt;
  logic             zcd_fall;
  logic             ph_clr, wd_clr, on_entry, on_end;

  crm_fall_det #(.INIT(1'b1)) u_zcd_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (zcd_i),
    .fall_o(zcd_fall)
  );

  // phase timer: restarts at every state change
  crm_cycle_timer #(.W(PH_W)) u_ph_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (ph_clr),
    .cnt_o (ph_cnt)
  );

  // watchdog: runs from the first off cycle through blank and wait
  crm_cycle_timer #(.W(WD_W)) u_wd_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (wd_clr),
    .cnt_o (wd_cnt)
  );

  assign on_end = (ilim_i && ph_cnt >= LEB_TH)
               || (ton_done_i && imin_i && ph_cnt >= TMIN_TH)
               || (ph_cnt >= TMAX_TH);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  state_d = ST_ON;
      ST_ON:    if (on_end) state_d = ST_BLANK;
      ST_BLANK: if (ph_cnt >= ZBL_TH) state_d = ST_WAIT;
      ST_WAIT: begin
        if (zcd_fall)              state_d = ST_DELAY;  // event wins over expiry
        else if (wd_cnt >= WD_TH)  state_d = ST_ON;
      end
      ST_DELAY: if (ph_cnt >= ZDLY_TH) state_d = ST_ON;
      default:  state_d = ST_IDLE;
    endcase
    if (stop_i) state_d = ST_IDLE;
  end

  assign ph_clr   = stop_i || (state_d != state_q);
  assign wd_clr   = stop_i || (state_q == ST_ON) || (state_q == ST_IDLE);
  assign on_entry = (state_d == ST_ON) && (state_q != ST_ON);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cycle_cnt_o <= '0;
      timeout_o   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (on_entry) begin
        cycle_cnt_o <= cycle_cnt_o + 1'b1;
        timeout_o   <= (state_q == ST_WAIT);
      end
    end
  end

  assign drv_o = (state_q == ST_ON) && !stop_i;
endmodule

// File: rtl/crm_gate_seq_chk.sv
module crm_gate_seq_chk #(
  parameter int LEB_CYC     = 13,
  parameter int TON_MIN_CYC = 30,
  parameter int TON_MAX_CYC = 900,
  parameter int ZBLANK_CYC  = 15,
  parameter int ZDLY_CYC    = 25,
  parameter int WD_CYC      = 1600,
  parameter int CYC_W       = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             stop_i,
  input logic             drv_o,
  input logic [CYC_W-1:0] cycle_cnt_o,
  input logic             timeout_o
);
  localparam int CW = $clog2(TON_MAX_CYC + WD_CYC + ZDLY_CYC + 2) + 1;
  localparam logic [CW-1:0] LEB_L  = CW'(LEB_CYC);
  localparam logic [CW-1:0] TMAX_L = CW'(TON_MAX_CYC - 1);
  localparam logic [CW-1:0] OFF_MX = CW'(WD_CYC + ZDLY_CYC - 1);
  localparam logic [CW-1:0] WD_L   = CW'(WD_CYC);
  localparam logic [CW-1:0] OFF_MN = CW'(ZBLANK_CYC + 1 + ZDLY_CYC);

  logic [CW-1:0] on_len, off_len;
  logic          stp;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      on_len  <= '0;
      off_len <= '0;
      stp     <= 1'b1;
    end else begin
      on_len  <= drv_o ? on_len + 1'b1 : '0;
      off_len <= drv_o ? '0 : ((off_len != '1) ? off_len + 1'b1 : off_len);
      stp     <= stop_i | (stp & ~drv_o);
    end
  end

  assert_stop_kills_drive_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |-> !drv_o);

  assert_leb_respected_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(drv_o) && !stop_i) |-> ($past(on_len) >= LEB_L));

  assert_max_on_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drv_o |-> (on_len <= TMAX_L));

  assert_zcd_blank_min_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(drv_o) && !timeout_o && !stp) |-> (off_len >= OFF_MN));

  assert_watchdog_length_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(drv_o) && timeout_o) |-> (off_len == WD_L));

  assert_off_bounded_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!drv_o && !stp) |-> (off_len <= OFF_MX));

  assert_count_step_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drv_o) |-> (cycle_cnt_o == $past(cycle_cnt_o) + 1'b1));

  assert_count_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$rose(drv_o) && !$rose(stp)) |-> $stable(cycle_cnt_o));
endmodule

bind crm_gate_seq crm_gate_seq_chk #(
  .LEB_CYC    (LEB_CYC),
  .TON_MIN_CYC(TON_MIN_CYC),
  .TON_MAX_CYC(TON_MAX_CYC),
  .ZBLANK_CYC (ZBLANK_CYC),
  .ZDLY_CYC   (ZDLY_CYC),
  .WD_CYC     (WD_CYC),
  .CYC_W      (CYC_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .stop_i     (stop_i),
  .drv_o      (drv_o),
  .cycle_cnt_o(cycle_cnt_o),
  .timeout_o  (timeout_o)
);

// File: tb/crm_gate_seq_test.sv
module crm_gate_seq_test;
  localparam int LEB   = 3;
  localparam int TMIN  = 6;
  localparam int TMAX  = 20;
  localparam int ZBL   = 4;
  localparam int ZDLY  = 5;
  localparam int WD    = 30;
  localparam int CW    = 8;
  localparam int NEVER = 100;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic stop_i = 1'b1;
  logic ton_done_i = 1'b0, ilim_i = 1'b0, imin_i = 1'b0, zcd_i = 1'b1;
  logic drv_o;
  logic [CW-1:0] cycle_cnt_o;
  logic timeout_o;

  int checks = 0;
  int errors = 0;
  logic [CW-1:0] exp_cnt = '0;

  always #10 clk_i = ~clk_i;

  crm_gate_seq #(
    .LEB_CYC(LEB), .TON_MIN_CYC(TMIN), .TON_MAX_CYC(TMAX),
    .ZBLANK_CYC(ZBL), .ZDLY_CYC(ZDLY), .WD_CYC(WD), .CYC_W(CW)
  ) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .stop_i(stop_i),
    .ton_done_i(ton_done_i), .ilim_i(ilim_i), .imin_i(imin_i), .zcd_i(zcd_i),
    .drv_o(drv_o), .cycle_cnt_o(cycle_cnt_o), .timeout_o(timeout_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int imin3(input int a, input int b, input int c);
    int r = a;
    if (b < r) r = b;
    if (c < r) r = c;
    return r;
  endfunction

  // called at a falling edge where drv_o has just been seen high
  task automatic do_cycle(input int k, input int j, input int m, input int zi,
                          input string req_on, input string req_off);
    int n = 0;
    int o = 0;
    int exp_on, exp_off, ramp_len, ilim_len;
    bit exp_to;
    ramp_len = (k >= NEVER || m >= NEVER) ? NEVER : imax(imax(k, m), TMIN - 1) + 1;
    ilim_len = (j >= NEVER) ? NEVER : imax(j, LEB) + 1;
    exp_on   = imin3(ramp_len, ilim_len, TMAX);
    while (drv_o && n < 200) begin
      ton_done_i = (n >= k);
      ilim_i     = (n >= j);
      imin_i     = (n >= m);
      zcd_i      = 1'b1;
      @(negedge clk_i);
      n++;
    end
    ton_done_i = 1'b0; ilim_i = 1'b0; imin_i = 1'b0;
    chk(req_on, n, exp_on);
    exp_to  = !(zi >= ZBL && zi <= WD - 1);
    exp_off = exp_to ? WD : zi + 1 + ZDLY;
    while (!drv_o && o < 400) begin
      zcd_i = (o < zi);
      @(negedge clk_i);
      o++;
    end
    zcd_i = 1'b1;
    chk(req_off, o, exp_off);
    exp_cnt = exp_cnt + 1'b1;
    chk("R9 timeout flag", int'(timeout_o), int'(exp_to));
    chk("R10 cycle count", int'(cycle_cnt_o), int'(exp_cnt));
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk_i);
    chk("R1 drv in reset", int'(drv_o), 0);
    chk("R1 count in reset", int'(cycle_cnt_o), 0);
    chk("R1 timeout in reset", int'(timeout_o), 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk("R2 held idle by stop", int'(drv_o), 0);
    stop_i = 1'b0;
    @(negedge clk_i);
    chk("R1 first on after reset", int'(drv_o), 1);
    exp_cnt = exp_cnt + 1'b1;
    chk("R10 first count", int'(cycle_cnt_o), int'(exp_cnt));

    // on-phase sweep: ramp index, peak-limit index, min-current index (R3 R4 R5 R6)
    for (int mi = 0; mi < 3; mi++) begin
      for (int ji = 0; ji < 5; ji++) begin
        for (int k = 0; k <= TMAX + 1; k++) begin
          int m = (mi == 0) ? 0 : (mi == 1) ? 8 : NEVER;
          int j = (ji == 0) ? 0 : (ji == 1) ? 2 : (ji == 2) ? 3 : (ji == 3) ? 5 : NEVER;
          int kk = (k > TMAX) ? NEVER : k;
          do_cycle(kk, j, m, 10, "R3 R4 R5 R6 on length", "R8 off length");
        end
      end
    end

    // off-phase sweep: zero-current index (R7 R8 R9)
    for (int zi = 0; zi <= WD + 2; zi++)
      do_cycle(0, NEVER, 0, zi, "R3 on length", "R7 R8 R9 off length");
    do_cycle(0, NEVER, 0, NEVER, "R3 on length", "R9 no event off length");

    // R2 stop during on phase
    repeat (2) @(negedge clk_i);
    stop_i = 1'b1;
    #1;
    chk("R2 drive killed at once", int'(drv_o), 0);
    repeat (3) @(negedge clk_i);
    chk("R2 stays low while stopped", int'(drv_o), 0);
    stop_i = 1'b0;
    @(negedge clk_i);
    chk("R2 restart after stop", int'(drv_o), 1);
    exp_cnt = exp_cnt + 1'b1;
    chk("R2 timeout clear after stop", int'(timeout_o), 0);
    chk("R10 count after stop", int'(cycle_cnt_o), int'(exp_cnt));
    do_cycle(0, NEVER, 0, NEVER, "R2 fresh on length", "R9 off length");

    // R2 stop during the zero-current wait clears the watchdog
    ton_done_i = 1'b1; imin_i = 1'b1;
    while (drv_o) @(negedge clk_i);
    ton_done_i = 1'b0; imin_i = 1'b0;
    repeat (20) @(negedge clk_i);
    stop_i = 1'b1;
    repeat (2) @(negedge clk_i);
    chk("R2 low during stop in off phase", int'(drv_o), 0);
    stop_i = 1'b0;
    @(negedge clk_i);
    chk("R2 restart from off phase", int'(drv_o), 1);
    exp_cnt = exp_cnt + 1'b1;
    chk("R2 no timeout flag", int'(timeout_o), 0);
    do_cycle(0, NEVER, 0, 12, "R2 on after restart", "R2 R8 watchdog cleared");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule